// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Integer Pipeline

This block is the control side of exception handling for an in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Every stage raises fault flags for the instruction it currently holds. The controller attaches a cause code to each instruction and carries that code down the pipeline alongside the instruction's PC. The first fault an instruction collects is the one it keeps. An exception is only acted on when the instruction leaves the memory stage. At that point everything older has already retired, so faults are taken strictly in program order, even if a younger instruction reported its fault in an earlier cycle.

When an exception is taken, the controller raises a flush that zeroes every pipeline register from fetch/decode through memory/writeback. This squashes the faulting instruction and everything younger. In the same cycle it redirects fetch to a fixed trap vector. It also latches the cause, a terminate flag and two restart PCs. The second PC makes it possible to restart an instruction that sits in the slot after a delayed branch. Further faults are ignored until a return-from-exception request arrives. That request sends fetch back to the first saved PC, and the fetch unit takes the second saved PC next. Overflow and misaligned-access faults can be masked by the user. A masked fault is simply dropped and the instruction continues.

Top module: `excp_ctrl`

## Requirements
- R1: After reset, flush and redir_valid are low, in_handler and term_q are low, and cause_q, epc0 and epc1 are zero.
- R2: Cause codes are fixed by source. Fetch raises page fault = 1, misaligned = 2, protection = 3 on if_flt[0], [1], [2]. Decode raises illegal opcode = 4 on id_ill. Execute raises overflow = 5 on ex_ovf. Memory raises page fault = 6, misaligned = 7, protection = 8 on mem_flt[0], [1], [2]. If one stage raises several flags together, the lowest code wins. The code of the taken exception appears on cause_q one cycle after the flush.
- R3: An instruction keeps the first fault it records. A fault raised by a later stage for the same instruction does not replace it.
- R4: An exception is taken in the cycle its instruction leaves the memory stage (adv high). In that cycle flush and redir_valid are high and redir_pc equals TRAP_VEC. In every other cycle flush is low.
- R5: Faults are taken in program order. An older instruction's fault wins over a younger one's, whether the younger fault was raised earlier or in the same cycle. The younger instruction is squashed and its fault is not taken.
- R6: With mask_ovf high, code 5 is dropped. With mask_mis high, codes 2 and 7 are dropped. A dropped fault is never taken and the instruction proceeds. Codes 1, 3, 4, 6 and 8 cannot be masked.
- R7: On a take, epc0 latches the faulting instruction's PC. epc1 latches the PC of the instruction behind it in the execute stage, which may be a branch target. If that slot holds a bubble, epc1 latches epc0 + INSN_BYTES.
- R8: After a take, in_handler is high and term_q is high exactly when cause_q is 4 (illegal opcode, a terminating event).
- R9: While in_handler is high, no fault causes a flush or a redirect.
- R10: rfe while in_handler is high drives redir_valid with redir_pc equal to epc0 in that cycle, and in_handler is low in the next cycle. rfe while in_handler is low has no effect: redir_valid stays low.
- R11: While adv is low, the tracked instructions hold their stages and no exception is taken. The held exception is taken on the first cycle adv is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Pipeline registers advance this cycle |
| if_valid | input | 1 | Fetch stage holds a real instruction |
| if_pc | input | PC_W | PC of the instruction in fetch |
| if_flt | input | 3 | Fetch faults: [0] page fault, [1] misaligned, [2] protection |
| id_ill | input | 1 | Decode found an illegal opcode |
| ex_ovf | input | 1 | Execute raised an arithmetic overflow |
| mem_flt | input | 3 | Memory faults: [0] page fault, [1] misaligned, [2] protection |
| mask_ovf | input | 1 | User mask for overflow |
| mask_mis | input | 1 | User mask for misaligned accesses |
| rfe | input | 1 | Return-from-exception request |
| flush | output | 1 | Zero all pipeline registers up to memory/writeback |
| redir_valid | output | 1 | Fetch must redirect to redir_pc |
| redir_pc | output | PC_W | Redirect target: trap vector or first restart PC |
| in_handler | output | 1 | An exception has been taken and not yet returned from |
| cause_q | output | 4 | Latched cause code of the taken exception |
| term_q | output | 1 | Taken exception is terminating |
| epc0 | output | PC_W | First restart PC (faulting instruction) |
| epc1 | output | PC_W | Second restart PC (its successor) |

## Verification
The bench places two faults on instructions zero to three slots apart. It sweeps every pair of source kinds and every mask setting, so an older memory-stage fault and a younger fetch or decode fault can fall in the same cycle, or the younger one can arrive first. The expected winner comes from program order and masking alone, and its cycle is the older survivor's fetch slot plus three. The bench checks the flush cycle, the latched cause and both restart PCs. It also checks that the loser's later flags produce no second flush while in the handler.

// File: rtl/excp_pkg.sv
// Shared constants for the exception controller: cause codes, the
// position of each source bit in the packed fault vector, and the
// per-stage slice of that vector. Assumes eight fault sources in the
// fixed order fetch(3), decode(1), execute(1), memory(3).
package excp_pkg;
    localparam int CAUSE_W = 4;
    localparam int NSRC    = 8;
    localparam int NSTAGE  = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_IPF   = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_IMIS  = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_IPROT = 4'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_ILL   = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_DPF   = 4'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_DMIS  = 4'd7;
    localparam logic [CAUSE_W-1:0] CAUSE_DPROT = 4'd8;

    // bit j of the source vector carries cause j+1; maskable: 2, 5, 7
    localparam logic [NSRC-1:0] MASKABLE = 8'b0101_0010;

    // first source bit owned by a stage (0 fetch .. 3 memory)
    function automatic int stg_first(int s);
        case (s)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    // number of source bits owned by a stage
    function automatic int stg_cnt(int s);
        return (s == 0 || s == 3) ? 3 : 1;
    endfunction
endpackage

// File: rtl/excp_src_enc.sv
// Per-stage fault encoder: turns one stage's fault flags into a cause
// code after removing masked flags; the lowest surviving flag wins.
// Assumes BASE is the cause code of flag bit 0.
module excp_src_enc
    import excp_pkg::*;
#(
    parameter int N    = 3,
    parameter int BASE = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       flags,
    input  logic [N-1:0]       drop,
    output logic [CAUSE_W-1:0] code
);
    logic [N-1:0] live;

    // flags that survive the user mask
    assign live = flags & ~drop;

    // priority pick, lowest bit (lowest code) last so it wins
    always_comb begin
        code = CAUSE_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) code = CAUSE_W'(BASE + i);
        end
    end

    AST_ENC_SRC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (code != CAUSE_NONE) |-> (|(flags & ~drop))); // R6
    AST_ENC_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & ~drop)) |-> (code == CAUSE_NONE)); // R2
endmodule

// File: rtl/excp_tag_pipe.sv
// Tag pipeline: shadows the decode, execute and memory pipeline
// registers with a valid bit, a first-fault cause and the PC of each
// instruction. Assumes the datapath registers advance exactly when adv
// is high and are zeroed when flush is high.
module excp_tag_pipe
    import excp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               flush,
    input  logic               rec_en,
    input  logic               if_valid,
    input  logic [PC_W-1:0]    if_pc,
    input  logic [CAUSE_W-1:0] code_if,
    input  logic [CAUSE_W-1:0] code_id,
    input  logic [CAUSE_W-1:0] code_ex,
    output logic               x_valid,
    output logic [PC_W-1:0]    x_pc,
    output logic               m_valid,
    output logic [CAUSE_W-1:0] m_cause,
    output logic [PC_W-1:0]    m_pc
);
    logic               d_valid;
    logic [CAUSE_W-1:0] d_cause;
    logic [PC_W-1:0]    d_pc;
    logic [CAUSE_W-1:0] x_cause;
    logic [CAUSE_W-1:0] d_next, x_next, m_next;

    // cause each instruction carries into its next stage; first fault kept
    always_comb begin
        d_next = (if_valid && rec_en) ? code_if : CAUSE_NONE;
        x_next = (d_cause != CAUSE_NONE) ? d_cause
               : ((d_valid && rec_en) ? code_id : CAUSE_NONE);
        m_next = (x_cause != CAUSE_NONE) ? x_cause
               : ((x_valid && rec_en) ? code_ex : CAUSE_NONE);
    end

    // shift, hold or clear the three stage tags
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            d_valid <= 1'b0;
            d_cause <= CAUSE_NONE;
            d_pc    <= '0;
            x_valid <= 1'b0;
            x_cause <= CAUSE_NONE;
            x_pc    <= '0;
            m_valid <= 1'b0;
            m_cause <= CAUSE_NONE;
            m_pc    <= '0;
        end else if (adv) begin
            d_valid <= if_valid;
            d_cause <= d_next;
            d_pc    <= if_pc;
            x_valid <= d_valid;
            x_cause <= x_next;
            x_pc    <= d_pc;
            m_valid <= x_valid;
            m_cause <= m_next;
            m_pc    <= x_pc;
        end
    end

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !flush && x_cause != CAUSE_NONE) |=> (m_cause == $past(x_cause))); // R3
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !flush) |=> ($stable(m_pc) && $stable(m_valid) && $stable(m_cause))); // R11
endmodule

// File: rtl/excp_commit.sv
// Commit point: decides at the memory/writeback boundary whether the
// outgoing instruction takes an exception, then holds cause, terminate
// flag and both restart PCs until a return request. Assumes the
// instruction in the execute tag is the outgoing one's successor.
module excp_commit
    import excp_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] TRAP_VEC   = 'h80,
    parameter int              INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               m_valid,
    input  logic [CAUSE_W-1:0] m_cause,
    input  logic [CAUSE_W-1:0] code_mem,
    input  logic [PC_W-1:0]    m_pc,
    input  logic               x_valid,
    input  logic [PC_W-1:0]    x_pc,
    input  logic               rfe,
    output logic               take,
    output logic               redir_valid,
    output logic [PC_W-1:0]    redir_pc,
    output logic               in_handler,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               term_q,
    output logic [PC_W-1:0]    epc0,
    output logic [PC_W-1:0]    epc1
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic [CAUSE_W-1:0] fin_cause;
    logic               rfe_go;

    // final cause of the outgoing instruction and the take decision
    always_comb begin
        fin_cause = (m_cause != CAUSE_NONE) ? m_cause : code_mem;
        take      = adv && m_valid && (fin_cause != CAUSE_NONE) && !in_handler;
        rfe_go    = rfe && in_handler;
    end

    // fetch redirect: trap vector on a take, first restart PC on return
    always_comb begin
        redir_valid = take || rfe_go;
        redir_pc    = take ? TRAP_VEC : epc0;
    end

    // handler state, cause and restart PCs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_handler <= 1'b0;
            cause_q    <= CAUSE_NONE;
            term_q     <= 1'b0;
            epc0       <= '0;
            epc1       <= '0;
        end else if (take) begin
            in_handler <= 1'b1;
            cause_q    <= fin_cause;
            term_q     <= (fin_cause == CAUSE_ILL);
            epc0       <= m_pc;
            epc1       <= x_valid ? x_pc : m_pc + STEP;
        end else if (rfe_go) begin
            in_handler <= 1'b0;
        end
    end

    AST_TAKE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> in_handler); // R9
    AST_RFE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && in_handler) |=> !in_handler); // R10
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |-> (cause_q != CAUSE_NONE)); // R8
    AST_TERM_ILL: assert property (@(posedge clk) disable iff (!rst_n)
        term_q |-> (cause_q == CAUSE_ILL)); // R8
    AST_EPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && $past(in_handler)) |-> ($stable(epc0) && $stable(epc1))); // R7
endmodule

// File: rtl/excp_ctrl.sv
// Precise exception controller top: packs the stage fault flags,
// applies user masks, encodes one cause per stage, tracks causes per
// instruction and commits them in program order. Assumes the pipeline
// registers follow adv and are cleared by flush.
module excp_ctrl
    import excp_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] TRAP_VEC   = 'h80,
    parameter int              INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               if_valid,
    input  logic [PC_W-1:0]    if_pc,
    input  logic [2:0]         if_flt,
    input  logic               id_ill,
    input  logic               ex_ovf,
    input  logic [2:0]         mem_flt,
    input  logic               mask_ovf,
    input  logic               mask_mis,
    input  logic               rfe,
    output logic               flush,
    output logic               redir_valid,
    output logic [PC_W-1:0]    redir_pc,
    output logic               in_handler,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               term_q,
    output logic [PC_W-1:0]    epc0,
    output logic [PC_W-1:0]    epc1
);
    logic [NSRC-1:0]    src;
    logic [NSRC-1:0]    drop;
    logic [CAUSE_W-1:0] stage_code [NSTAGE];
    logic               x_valid, m_valid;
    logic [PC_W-1:0]    x_pc, m_pc;
    logic [CAUSE_W-1:0] m_cause;

    // pack sources so that bit j carries cause j+1; build the drop mask
    always_comb begin
        src  = {mem_flt, ex_ovf, id_ill, if_flt};
        drop = MASKABLE & {1'b0, mask_mis, 1'b0, mask_ovf, 1'b0, 1'b0, mask_mis, 1'b0};
    end

    // one encoder per stage over that stage's slice of the sources
    for (genvar g = 0; g < NSTAGE; g++) begin : g_enc
        excp_src_enc #(
            .N    (stg_cnt(g)),
            .BASE (stg_first(g) + 1)
        ) u_enc (
            .clk   (clk),
            .rst_n (rst_n),
            .flags (src[stg_first(g) +: stg_cnt(g)]),
            .drop  (drop[stg_first(g) +: stg_cnt(g)]),
            .code  (stage_code[g])
        );
    end

    excp_tag_pipe #(
        .PC_W (PC_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .flush    (flush),
        .rec_en   (!in_handler),
        .if_valid (if_valid),
        .if_pc    (if_pc),
        .code_if  (stage_code[0]),
        .code_id  (stage_code[1]),
        .code_ex  (stage_code[2]),
        .x_valid  (x_valid),
        .x_pc     (x_pc),
        .m_valid  (m_valid),
        .m_cause  (m_cause),
        .m_pc     (m_pc)
    );

    excp_commit #(
        .PC_W       (PC_W),
        .TRAP_VEC   (TRAP_VEC),
        .INSN_BYTES (INSN_BYTES)
    ) u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .m_valid     (m_valid),
        .m_cause     (m_cause),
        .code_mem    (stage_code[3]),
        .m_pc        (m_pc),
        .x_valid     (x_valid),
        .x_pc        (x_pc),
        .rfe         (rfe),
        .take        (flush),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .in_handler  (in_handler),
        .cause_q     (cause_q),
        .term_q      (term_q),
        .epc0        (epc0),
        .epc1        (epc1)
    );

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!m_valid && !x_valid)); // R4
    AST_NO_TAKE_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_handler) && in_handler |-> !(flush && $past(flush))); // R9
endmodule

// File: tb/tb_excp_ctrl.sv
`timescale 1ns/1ps
module tb_excp_ctrl;
    localparam logic [31:0] TRAP = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv, if_valid, id_ill, ex_ovf, mask_ovf, mask_mis, rfe;
    logic [31:0] if_pc;
    logic [2:0]  if_flt, mem_flt;
    logic        flush, redir_valid, in_handler, term_q;
    logic [31:0] redir_pc, epc0, epc1;
    logic [3:0]  cause_q;

    int          errs = 0;
    int          checks = 0;
    logic [31:0] pc_ctr = 32'h0000_1000;

    always #2.5 clk = ~clk;

    excp_ctrl #(.PC_W(32), .TRAP_VEC(TRAP), .INSN_BYTES(4)) dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .if_valid(if_valid), .if_pc(if_pc),
        .if_flt(if_flt), .id_ill(id_ill), .ex_ovf(ex_ovf), .mem_flt(mem_flt),
        .mask_ovf(mask_ovf), .mask_mis(mask_mis), .rfe(rfe), .flush(flush),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .in_handler(in_handler),
        .cause_q(cause_q), .term_q(term_q), .epc0(epc0), .epc1(epc1)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // stage in which a cause code is raised (0 fetch .. 3 memory)
    function automatic int stg(input int c);
        return (c <= 3) ? 0 : (c == 4) ? 1 : (c == 5) ? 2 : 3;
    endfunction

    function automatic bit eff(input int c, input bit mo, input bit mm);
        return c != 0 && !((c == 5 && mo) || ((c == 2 || c == 7) && mm));
    endfunction

    task automatic raise(input int c);
        case (c)
            1: if_flt[0]  = 1'b1;
            2: if_flt[1]  = 1'b1;
            3: if_flt[2]  = 1'b1;
            4: id_ill     = 1'b1;
            5: ex_ovf     = 1'b1;
            6: mem_flt[0] = 1'b1;
            7: mem_flt[1] = 1'b1;
            8: mem_flt[2] = 1'b1;
            default: ;
        endcase
    endtask

    // drive one cycle of inputs at the falling edge and let them settle
    task automatic tick(input bit v, input logic [31:0] pc, input int c1, input int c2, input bit a);
        @(negedge clk);
        if_valid = v; if_pc = pc; adv = a; rfe = 1'b0;
        if_flt = '0; id_ill = 1'b0; ex_ovf = 1'b0; mem_flt = '0;
        raise(c1);
        raise(c2);
        #1;
    endtask

    // two faults on instructions d apart (d = 0: same instruction)
    task automatic scenario(input int a, input int b, input int d, input bit mo, input bit mm);
        bit          win;
        int          widx, wc;
        logic [31:0] pc0;
        string       ftag;
        win = 1'b0; widx = 0; wc = 0;
        if (d == 0) begin
            if (eff(a, mo, mm)) begin win = 1'b1; wc = a; end
            if (eff(b, mo, mm) && (!win || b < wc)) begin win = 1'b1; wc = b; end
        end else if (eff(a, mo, mm)) begin
            win = 1'b1; wc = a;
        end else if (eff(b, mo, mm)) begin
            win = 1'b1; wc = b; widx = d;
        end
        mask_ovf = mo; mask_mis = mm;
        pc0 = pc_ctr;
        ftag = ((a != 0 && !eff(a, mo, mm)) || (b != 0 && !eff(b, mo, mm))) ? "R6"
             : (d > 0 && a != 0 && b != 0) ? "R5" : "R4";
        for (int rel = 0; rel < 8; rel++) begin
            tick(1'b1, pc_ctr,
                 (a != 0 && rel == stg(a)) ? a : 0,
                 (b != 0 && rel == d + stg(b)) ? b : 0, 1'b1);
            pc_ctr += 4;
            if (win && rel > widx + 3)
                check("R9 flush in handler", 32'(flush), 32'd0);
            else
                check(ftag, 32'(flush), 32'(win && rel == widx + 3));
            if (win && rel == widx + 3)
                check("R4 trap vector", redir_pc, TRAP);
        end
        tick(1'b1, pc_ctr, 0, 0, 1'b1);
        pc_ctr += 4;
        check("R8 handler", 32'(in_handler), 32'(win));
        if (win) begin
            check((d == 0 && a != 0 && b != 0) ? "R3 cause" : "R2 cause", 32'(cause_q), 32'(wc));
            check("R8 term", 32'(term_q), 32'(wc == 4));
            check("R7 epc0", epc0, pc0 + 32'(4 * widx));
            check("R7 epc1", epc1, pc0 + 32'(4 * widx) + 32'd4);
        end
        rfe = 1'b1;
        #1;
        check("R10 rfe redirect", 32'(redir_valid), 32'(win));
        if (win) check("R10 rfe target", redir_pc, pc0 + 32'(4 * widx));
        tick(1'b1, pc_ctr, 0, 0, 1'b1);
        pc_ctr += 4;
        check("R10 handler exit", 32'(in_handler), 32'd0);
        tick(1'b1, pc_ctr, 0, 0, 1'b1);
        pc_ctr += 4;
    endtask

    task automatic do_rfe();
        rfe = 1'b1;
        #1;
        tick(1'b1, pc_ctr, 0, 0, 1'b1);
        pc_ctr += 4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] p;
        rst_n = 1'b0; adv = 1'b1; if_valid = 1'b0; if_pc = '0; if_flt = '0;
        id_ill = 1'b0; ex_ovf = 1'b0; mem_flt = '0; mask_ovf = 1'b0; mask_mis = 1'b0; rfe = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(1'b0, 32'd0, 0, 0, 1'b1);
        check("R1 flush", 32'(flush), 32'd0);
        check("R1 redir", 32'(redir_valid), 32'd0);
        check("R1 handler", 32'(in_handler), 32'd0);
        check("R1 cause", 32'(cause_q), 32'd0);
        check("R1 term", 32'(term_q), 32'd0);
        check("R1 epc0", epc0, 32'd0);
        check("R1 epc1", epc1, 32'd0);
        for (int k = 0; k < 4; k++) begin
            tick(1'b1, pc_ctr, 0, 0, 1'b1);
            pc_ctr += 4;
        end

        // sweep: every source pair, distance and mask setting
        for (int mk = 0; mk < 4; mk++)
            for (int d = 0; d < 4; d++)
                for (int a = 0; a < 9; a++)
                    for (int b = 0; b < 9; b++)
                        scenario(a, b, d, mk[0], mk[1]);

        // R11: stall while the faulting instruction sits in memory
        p = pc_ctr;
        tick(1'b1, p, 1, 0, 1'b1);
        tick(1'b1, p + 4, 0, 0, 1'b1);
        tick(1'b1, p + 8, 0, 0, 1'b1);
        tick(1'b1, p + 12, 0, 0, 1'b0);
        check("R11 no take while stalled", 32'(flush), 32'd0);
        tick(1'b1, p + 12, 0, 0, 1'b0);
        check("R11 still held", 32'(flush), 32'd0);
        tick(1'b1, p + 12, 0, 0, 1'b1);
        check("R11 take on release", 32'(flush), 32'd1);
        pc_ctr = p + 16;
        tick(1'b1, pc_ctr, 0, 0, 1'b1);
        pc_ctr += 4;
        check("R11 epc0", epc0, p);
        check("R11 epc1", epc1, p + 4);
        do_rfe();

        // R7: successor is a branch target, not sequential
        p = pc_ctr;
        tick(1'b1, p, 0, 0, 1'b1);
        tick(1'b1, 32'h0000_9000, 0, 0, 1'b1);
        tick(1'b1, 32'h0000_9004, 0, 0, 1'b1);
        tick(1'b1, 32'h0000_9008, 6, 0, 1'b1);
        check("R7 delay-slot take", 32'(flush), 32'd1);
        tick(1'b1, 32'h0000_900c, 0, 0, 1'b1);
        check("R7 epc0 slot", epc0, p);
        check("R7 epc1 target", epc1, 32'h0000_9000);
        check("R2 data page fault", 32'(cause_q), 32'd6);
        pc_ctr = 32'h0000_9010;
        do_rfe();

        // R7/R8: bubble behind an illegal opcode
        p = pc_ctr;
        tick(1'b1, p, 0, 0, 1'b1);
        tick(1'b0, 32'hdead_0000, 4, 0, 1'b1);
        tick(1'b1, p + 8, 0, 0, 1'b1);
        tick(1'b1, p + 12, 0, 0, 1'b1);
        check("R4 illegal take", 32'(flush), 32'd1);
        tick(1'b1, p + 16, 0, 0, 1'b1);
        check("R7 epc1 bubble", epc1, p + 4);
        check("R8 terminate", 32'(term_q), 32'd1);
        pc_ctr = p + 20;
        do_rfe();

        finish_run();
    end
endmodule